// File: doc/BRIEF.md
# Two-Phase Lockstep Step Coordinator

This block paces a group of concurrent simulated components through lockstep steps. Each step has two stages, and a barrier closes each one. In the first stage, the speak stage, each component either emits its output or declines. In the second stage, the move stage, each component either updates its state or declines. The coordinator hands out permits for each stage. It accepts a finish signal from each component and counts how many components were due to fire (imminent) in the step. It opens the next stage only when every component has finished the current one.

A component that is imminent may not decline the speak stage. Its scheduled event outranks the option to pass. The move stage is opened only when at least one component fired in the step. If no component fired but inputs are still pending, the speak stage is issued again. If no component fired and nothing is pending, the group can never advance. The coordinator then raises a sticky stall flag and stops handing out permits. A step counter records each completed move stage.

Top module: `evc_step_coordinator`

## Requirements
- R1: While reset is high, and in the first cycle after it, every speak permit is set. Every move permit is clear, and the imminent count, pending flags, stall flag and step counter are all zero.
- R2: During the speak stage, an imminent component finishes only through `spk_done` and a non-imminent component finishes only through `spk_pass`. The component's speak permit clears at the clock edge that samples the accepted signal.
- R3: A `spk_pass` from an imminent component is ignored, and so is a `spk_done` from a non-imminent component. The permit stays set and the imminent count does not change.
- R4: Move permits are issued to all components one cycle after the last speak permit clears, and only if the imminent count is nonzero. No move permit is ever set while a speak permit is set.
- R5: In the move stage, either `mov_done` or `mov_pass` clears that component's move permit at the sampling edge. One cycle after the last move permit clears, every speak permit is set again, the step counter increments by one and the imminent count returns to zero.
- R6: An `in_event` bit sets the matching pending flag. An accepted `mov_done` or `mov_pass` clears it. If a set and a clear reach the same bit in the same cycle, the set wins.
- R7: The imminent count adds up the accepted emissions of one speak stage, even when they arrive in different cycles. It holds its value through the move stage.
- R8: Suppose the speak stage ends with a zero count while some pending flag is set. Then one cycle later every speak permit is reissued, no move permit is issued and the step counter does not change.
- R9: Suppose the speak stage ends with a zero count and no pending flag set. Then one cycle later `stall` rises and all permits are clear. This state holds, whatever the inputs do, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_imm | input | N | Level: the component is imminent in this step |
| in_event | input | N | Pulse: an input has been delivered to the component |
| spk_done | input | N | Pulse: the component emitted its output |
| spk_pass | input | N | Pulse: the component declines the speak stage |
| mov_done | input | N | Pulse: the component performed a transition |
| mov_pass | input | N | Pulse: the component declines the move stage |
| spk_permit | output | N | Speak permits, registered |
| mov_permit | output | N | Move permits, registered |
| pend_flags | output | N | Pending-input flags for each component |
| imm_count | output | clog2(N+1) | Number of components imminent in the current step |
| stall | output | 1 | Sticky: the group can never advance |
| step_count | output | SW | Completed steps |

## Verification
A wrong permit bit shows up at once on `spk_permit` or `mov_permit`. A stage that fails to close leaves no move permits one cycle after the speak permits clear, or no fresh speak permits one cycle after the move permits clear, so a stuck stage is visible within two cycles of the last finish signal. An imminent count that is wrong or is not cleared first appears on `imm_count`. It then shows again at the decision point, where it sends the block into a move stage, a retried speak stage or a stall, and that choice is visible on the permits and on `stall` one cycle later. Pending-flag errors are visible directly on `pend_flags` and change the retry-or-stall outcome.

// File: rtl/evc_pkg.sv
package evc_pkg;
  typedef enum logic [1:0] {
    PH_SPEAK = 2'd0,
    PH_MOVE  = 2'd1,
    PH_HALT  = 2'd2
  } phase_t;
endpackage

// File: rtl/evc_permit_bank.sv
// One permit flop per component: set on load, cleared on accepted finish.
module evc_permit_bank #(
  parameter int N       = 4,
  parameter bit RST_SET = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] accept,
  output logic [N-1:0] permit
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            permit[i] <= RST_SET;
      else if (load)      permit[i] <= 1'b1;
      else if (accept[i]) permit[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evc_pending_bank.sv
// Pending-input flags; a new event outranks a clear in the same cycle.
module evc_pending_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] clr_in,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flags[i] <= 1'b0;
      else if (set_in[i]) flags[i] <= 1'b1;
      else if (clr_in[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/evc_popcount.sv
module evc_popcount #(
  parameter int N = 4,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] vec,
  output logic [W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + W'(vec[i]);
  end
endmodule

// File: rtl/evc_step_coordinator.sv
module evc_step_coordinator
  import evc_pkg::*;
#(
  parameter int N  = 4,
  parameter int SW = 16,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  comp_imm,
  input  logic [N-1:0]  in_event,
  input  logic [N-1:0]  spk_done,
  input  logic [N-1:0]  spk_pass,
  input  logic [N-1:0]  mov_done,
  input  logic [N-1:0]  mov_pass,
  output logic [N-1:0]  spk_permit,
  output logic [N-1:0]  mov_permit,
  output logic [N-1:0]  pend_flags,
  output logic [CW-1:0] imm_count,
  output logic          stall,
  output logic [SW-1:0] step_count
);
  phase_t phase;

  logic [N-1:0]  emit_acc, spk_acc, mov_acc;
  logic [CW-1:0] emit_cnt;
  logic          speak_closed, move_closed;
  logic          load_speak, load_move;

  // Imminence outranks the option to pass.
  assign emit_acc = spk_permit & comp_imm & spk_done;
  assign spk_acc  = emit_acc | (spk_permit & ~comp_imm & spk_pass);
  assign mov_acc  = mov_permit & (mov_done | mov_pass);

  assign speak_closed = (phase == PH_SPEAK) && (spk_permit == '0);
  assign move_closed  = (phase == PH_MOVE)  && (mov_permit == '0);

  assign load_move  = speak_closed && (imm_count != '0);
  assign load_speak = move_closed ||
                      (speak_closed && (imm_count == '0) && (pend_flags != '0));

  evc_popcount #(.N(N), .W(CW)) u_emit_cnt (
    .vec (emit_acc),
    .cnt (emit_cnt)
  );

  evc_permit_bank #(.N(N), .RST_SET(1'b1)) u_speak_bank (
    .clk    (clk),
    .rst    (rst),
    .load   (load_speak),
    .accept (spk_acc),
    .permit (spk_permit)
  );

  evc_permit_bank #(.N(N), .RST_SET(1'b0)) u_move_bank (
    .clk    (clk),
    .rst    (rst),
    .load   (load_move),
    .accept (mov_acc),
    .permit (mov_permit)
  );

  evc_pending_bank #(.N(N)) u_pending (
    .clk    (clk),
    .rst    (rst),
    .set_in (in_event),
    .clr_in (mov_acc),
    .flags  (pend_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_SPEAK;
      imm_count  <= '0;
      stall      <= 1'b0;
      step_count <= '0;
    end else begin
      case (phase)
        PH_SPEAK: begin
          if (speak_closed) begin
            if (imm_count != '0) begin
              phase <= PH_MOVE;
            end else if (pend_flags == '0) begin
              phase <= PH_HALT;
              stall <= 1'b1;
            end
          end else begin
            imm_count <= imm_count + emit_cnt;
          end
        end
        PH_MOVE: begin
          if (move_closed) begin
            phase      <= PH_SPEAK;
            imm_count  <= '0;
            step_count <= step_count + 1'b1;
          end
        end
        default: begin
          phase <= PH_HALT;
          stall <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/evc_step_checker.sv
module evc_step_checker #(
  parameter int N  = 4,
  parameter int SW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  comp_imm,
  input logic [N-1:0]  spk_done,
  input logic [N-1:0]  spk_permit,
  input logic [N-1:0]  mov_permit,
  input logic [CW-1:0] imm_count,
  input logic          stall,
  input logic [SW-1:0] step_count
);
  a_r4_stage_exclusive: assert property (@(posedge clk) disable iff (rst)
    !((spk_permit != '0) && (mov_permit != '0)));

  a_r4_move_needs_count: assert property (@(posedge clk) disable iff (rst)
    (mov_permit != '0) |-> (imm_count != '0));

  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    imm_count <= CW'(N));

  a_r5_step_opens_speak: assert property (@(posedge clk) disable iff (rst)
    (step_count != $past(step_count)) |-> (spk_permit == '1));

  a_r9_stall_sticky: assert property (@(posedge clk) disable iff (rst)
    stall |=> stall);

  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    stall |-> ((spk_permit == '0) && (mov_permit == '0)));

  for (genvar i = 0; i < N; i++) begin : g_hold
    a_r3_imminent_holds_permit: assert property (@(posedge clk) disable iff (rst)
      (spk_permit[i] && comp_imm[i] && !spk_done[i]) |=> spk_permit[i]);
  end
endmodule

bind evc_step_coordinator evc_step_checker #(.N(N), .SW(SW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .comp_imm   (comp_imm),
  .spk_done   (spk_done),
  .spk_permit (spk_permit),
  .mov_permit (mov_permit),
  .imm_count  (imm_count),
  .stall      (stall),
  .step_count (step_count)
);

// File: tb/evc_step_coordinator_tb.sv
module evc_step_coordinator_tb;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  comp_imm = '0, in_event = '0;
  logic [N-1:0]  spk_done = '0, spk_pass = '0, mov_done = '0, mov_pass = '0;
  logic [N-1:0]  spk_permit, mov_permit, pend_flags;
  logic [CW-1:0] imm_count;
  logic          stall;
  logic [SW-1:0] step_count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  evc_step_coordinator #(.N(N), .SW(SW)) u_dut (
    .clk(clk), .rst(rst), .comp_imm(comp_imm), .in_event(in_event),
    .spk_done(spk_done), .spk_pass(spk_pass),
    .mov_done(mov_done), .mov_pass(mov_pass),
    .spk_permit(spk_permit), .mov_permit(mov_permit),
    .pend_flags(pend_flags), .imm_count(imm_count),
    .stall(stall), .step_count(step_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_pulses();
    in_event = '0; spk_done = '0; spk_pass = '0; mov_done = '0; mov_pass = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clr_pulses();
  endtask

  task automatic do_reset();
    rst = 1'b1; comp_imm = '0; clr_pulses();
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 speak permits", 32'(spk_permit), 32'hF);
    chk("R1 move permits", 32'(mov_permit), 0);
    chk("R1 count", 32'(imm_count), 0);
    chk("R1 pending", 32'(pend_flags), 0);
    chk("R1 stall", 32'(stall), 0);
    chk("R1 steps", 32'(step_count), 0);
  endtask

  task automatic t_full_step();
    do_reset();
    comp_imm = 4'b0101; spk_done = 4'b0101; spk_pass = 4'b1010; in_event = 4'b0010;
    tick();
    chk("R2 speak permits cleared", 32'(spk_permit), 0);
    chk("R7 count two", 32'(imm_count), 2);
    chk("R4 no move before barrier", 32'(mov_permit), 0);
    chk("R6 pending set", 32'(pend_flags), 32'h2);
    tick();
    chk("R4 move permits issued", 32'(mov_permit), 32'hF);
    chk("R7 count held in move", 32'(imm_count), 2);
    mov_done = 4'b1101; mov_pass = 4'b0010;
    tick();
    chk("R5 move permits cleared", 32'(mov_permit), 0);
    chk("R6 pass clears pending", 32'(pend_flags), 0);
    tick();
    chk("R5 fresh speak permits", 32'(spk_permit), 32'hF);
    chk("R5 step counted", 32'(step_count), 1);
    chk("R5 count reset", 32'(imm_count), 0);
  endtask

  task automatic t_imminent_priority();
    do_reset();
    comp_imm = 4'b0001; spk_pass = 4'b0001; spk_done = 4'b0010;
    tick();
    chk("R3 imminent pass ignored", 32'(spk_permit), 32'hF);
    chk("R3 count unchanged", 32'(imm_count), 0);
    spk_done = 4'b0001; spk_pass = 4'b0010;
    tick();
    chk("R2 accepted finishes", 32'(spk_permit), 32'hC);
    chk("R2 emission counted", 32'(imm_count), 1);
  endtask

  task automatic t_staggered();
    do_reset();
    comp_imm = 4'b0111;
    spk_done = 4'b0001; spk_pass = 4'b1000;
    tick();
    chk("R7 first partial count", 32'(imm_count), 1);
    chk("R2 partial permits", 32'(spk_permit), 32'h6);
    spk_done = 4'b0110;
    tick();
    chk("R7 accumulated count", 32'(imm_count), 3);
    chk("R4 move waits one cycle", 32'(mov_permit), 0);
    tick();
    chk("R4 move after last speak", 32'(mov_permit), 32'hF);
    in_event = 4'b0100; mov_done = 4'b0111;
    tick();
    chk("R6 set wins over clear", 32'(pend_flags), 32'h4);
    chk("R5 one move permit left", 32'(mov_permit), 32'h8);
    chk("R5 speak still closed", 32'(spk_permit), 0);
    mov_pass = 4'b1000;
    tick();
    tick();
    chk("R5 step after last move", 32'(step_count), 1);
  endtask

  task automatic t_retry();
    do_reset();
    comp_imm = '0; in_event = 4'b0001; spk_pass = 4'b1111;
    tick();
    chk("R8 pending present", 32'(pend_flags), 32'h1);
    tick();
    chk("R8 speak reissued", 32'(spk_permit), 32'hF);
    chk("R8 no move permits", 32'(mov_permit), 0);
    chk("R8 step unchanged", 32'(step_count), 0);
    chk("R8 no stall", 32'(stall), 0);
  endtask

  task automatic t_stall();
    do_reset();
    comp_imm = '0; spk_pass = 4'b1111;
    tick();
    tick();
    chk("R9 stall raised", 32'(stall), 1);
    chk("R9 speak permits low", 32'(spk_permit), 0);
    chk("R9 move permits low", 32'(mov_permit), 0);
    comp_imm = 4'b1111; spk_done = 4'b1111; mov_done = 4'b1111;
    tick();
    tick();
    chk("R9 stall held", 32'(stall), 1);
    chk("R9 inputs ignored", 32'({spk_permit, mov_permit}), 0);
    chk("R9 count untouched", 32'(imm_count), 0);
  endtask

  initial begin
    t_reset();
    t_full_step();
    t_imminent_priority();
    t_staggered();
    t_retry();
    t_stall();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule